// File: doc/BRIEF.md
# Configurable SPI Byte Shifter

This block moves one byte at a time over a four-wire serial link. It can act as the clock master or as a slave. As master it generates the serial clock at a programmable rate, drives a chip-select low for the length of the transfer, and shifts the byte out most significant bit first while it collects the returning bits. As slave it follows an external clock and select. It passes both through two-flop synchronisers before it uses them.

Writing a byte into the transmit buffer while the engine is idle starts an exchange. When the eighth bit has been captured, the received byte replaces the contents of the receive buffer and a buffer-full flag rises. Four configuration inputs set the exchange: the clock idle level, which clock edge moves outgoing data, where in the bit time the master captures incoming data, and the clock divider. A write that arrives while an exchange is still running is dropped and recorded in a sticky collision flag.

Top module: `spi_shift_engine`

## Requirements
- R1: In master mode (`isMaster`=1), a write (`wrEn`=1) while `busy`=0 starts an exchange. `csnOut` is 0 for as long as `busy` is 1. `sdoOut` presents the written byte most significant bit first.
- R2: In master mode `sckOut` rests at `clkPol` while no exchange runs. Each SCK half period lasts `divRatio`+1 clock cycles. `busy` drops and `done` pulses in the cycle that follows clock edge W+16×(`divRatio`+1), where W is the edge that accepted the write.
- R3: `sdoOut` changes only on the transmit edge of SCK. With `clkPol`=0 that edge is falling when `txEdge`=1 and rising when `txEdge`=0. With `clkPol`=1 it is rising when `txEdge`=1 and falling when `txEdge`=0. Incoming data is captured on the other edge, the mid point of the bit.
- R4: In master mode with `sampleEnd`=0, each incoming bit is captured at the middle of its output bit time. With `sampleEnd`=1 it is captured at the end of that bit time, just before `sdoOut` moves on.
- R5: In slave mode `sampleEnd` has no effect. Incoming bits are always captured on the edge opposite the transmit edge.
- R6: In slave mode (`isMaster`=0) the block follows `sckIn`, `ssnIn` and `sdiIn` with the same edge rules as R3. It shifts out the byte last written while `sdoOut` is enabled, and it delivers the received byte, most significant bit first, to `rdData`.
- R7: In slave mode `ssnIn`=1 clears the partial bit count, so a later exchange starts afresh from bit 7. It also drives `sdoOe` to 0. `sdoOe` is 1 while selected and always 1 in master mode.
- R8: `bufFull` is 0 after reset. It goes to 1 in the same cycle that `rdData` takes a received byte. A `rdEn` pulse returns it to 0.
- R9: A write while `busy`=1 does not alter the byte being shifted out and sets `wcolFlag`. The flag stays set until a `wcolClr` pulse.
- R10: `done` is a one-cycle pulse, issued once for each completed byte and never for an aborted one.
- R11: After reset `busy`, `done`, `bufFull` and `wcolFlag` are 0, `csnOut` is 1 and `sckOut` equals `clkPol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 selects master, 0 selects slave |
| clkPol | input | 1 | SCK idle level |
| txEdge | input | 1 | Transmit edge select (see R3) |
| sampleEnd | input | 1 | Master capture point: 0 mid-bit, 1 end of bit |
| divRatio | input | 8 | Half-period length minus one, in clock cycles |
| wrEn | input | 1 | Write strobe for the transmit byte |
| wrData | input | 8 | Byte to transmit |
| rdEn | input | 1 | Read strobe, clears bufFull |
| wcolClr | input | 1 | Clears the write-collision flag |
| rdData | output | 8 | Last received byte |
| bufFull | output | 1 | Received byte waiting |
| wcolFlag | output | 1 | Sticky write-collision flag |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion strobe |
| sckOut | output | 1 | Master serial clock |
| sdoOut | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for sdoOut |
| csnOut | output | 1 | Master chip select, active low |
| sckIn | input | 1 | Slave serial clock |
| ssnIn | input | 1 | Slave select, active low |
| sdiIn | input | 1 | Serial data in |

## Verification
In master mode the received byte, `bufFull` and `done` all become valid one cycle after edge W+16×(`divRatio`+1). The bench counts falling clock edges from the write and requires `done` at exactly count 16×(`divRatio`+1)+1. In slave mode the result arrives about three cycles after the final capture edge on `sckIn`, because of the synchronisers. The bench therefore holds every slave clock level for six cycles, and it lets a scoreboard keyed on `done` collect the byte whenever it appears. All outputs are read on falling clock edges. The responding model changes `sdiIn` only after an SCK transition is visible, and it injects a deliberately wrong value between the two capture points, so that a capture at the wrong point shows up as a wrong byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic load;       // accept a new transmit byte
    logic sampleNow;  // capture the input line this cycle
    logic shiftNow;   // advance the shift register by one bit
    logic finishNow;  // last bit: deliver the received byte
  } xferStrb_t;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             clkPol,
  input  logic             txEdge,
  input  logic             sampleEnd,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             wrEn,
  input  logic             sckIn,
  input  logic             ssnIn,
  input  logic             sdiIn,
  output xferStrb_t        strb,
  output logic             sdiBit,
  output logic             busy,
  output logic             sckOut,
  output logic             csnOut,
  output logic             slaveSel
);
  localparam int HALF_N = 2 * DATA_W;
  localparam int HIDX_W = $clog2(HALF_N);
  localparam int CNT_W  = $clog2(DATA_W + 1);

  // master timing state
  logic              busyM;
  logic [HIDX_W-1:0] halfIdx;
  logic [DIV_W-1:0]  divCnt;
  logic              tick, lastHalf, mMid, mEnd, useEnd, startXfer;

  // slave synchronisers and bit tracking
  logic [2:0]        sckSync;
  logic [1:0]        ssnSync;
  logic [1:0]        sdiSync;
  logic [CNT_W-1:0]  sBitCnt;
  logic              sPend;
  logic              sRise, sFall, sLead, sTrail, sTxEv, sSmpEv, sFinish, busySlave;

  assign slaveSel  = ~ssnSync[1];
  assign busySlave = slaveSel & ((sBitCnt != '0) | sPend);
  assign busy      = isMaster ? busyM : busySlave;
  assign startXfer = wrEn & ~busy;

  assign tick     = busyM & (divCnt >= divRatio);
  assign lastHalf = (halfIdx == HIDX_W'(HALF_N - 1));
  assign mMid     = tick & ~halfIdx[0];
  assign mEnd     = tick & halfIdx[0];
  assign useEnd   = sampleEnd & isMaster;  // slave mode forces mid-bit capture

  assign sRise   = sckSync[1] & ~sckSync[2];
  assign sFall   = ~sckSync[1] & sckSync[2];
  assign sLead   = clkPol ? sFall : sRise;
  assign sTrail  = clkPol ? sRise : sFall;
  assign sTxEv   = ~isMaster & slaveSel & (txEdge ? sTrail : sLead);
  assign sSmpEv  = ~isMaster & slaveSel & (txEdge ? sLead : sTrail);
  assign sFinish = sSmpEv & (sBitCnt == CNT_W'(DATA_W - 1));

  assign sdiBit = isMaster ? sdiIn : sdiSync[1];

  always_comb begin
    strb.load = startXfer;
    if (isMaster) begin
      strb.sampleNow = useEnd ? mEnd : mMid;
      strb.shiftNow  = mEnd & ~lastHalf;
      strb.finishNow = mEnd & lastHalf;
    end else begin
      strb.sampleNow = sSmpEv;
      strb.shiftNow  = sTxEv & sPend;
      strb.finishNow = sFinish;
    end
  end

  // SCK is active in odd half periods when data moves on the trailing edge,
  // in even half periods when it moves on the leading edge
  assign sckOut = clkPol ^ (isMaster & busyM & (halfIdx[0] ~^ txEdge));
  assign csnOut = ~(isMaster & busyM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyM   <= 1'b0;
      halfIdx <= '0;
      divCnt  <= '0;
    end else if (startXfer && isMaster) begin
      busyM   <= 1'b1;
      halfIdx <= '0;
      divCnt  <= '0;
    end else if (tick) begin
      divCnt  <= '0;
      halfIdx <= halfIdx + 1'b1;
      if (lastHalf) busyM <= 1'b0;
    end else if (busyM) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync <= '0;
      ssnSync <= 2'b11;
      sdiSync <= '0;
    end else begin
      sckSync <= {sckSync[1:0], sckIn};
      ssnSync <= {ssnSync[0], ssnIn};
      sdiSync <= {sdiSync[0], sdiIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || isMaster || !slaveSel) begin
      sBitCnt <= '0;
      sPend   <= 1'b0;
    end else if (sSmpEv) begin
      if (sFinish) begin
        sBitCnt <= '0;
        sPend   <= 1'b0;
      end else begin
        sBitCnt <= sBitCnt + 1'b1;
        sPend   <= 1'b1;
      end
    end else if (sTxEv && sPend) begin
      sPend <= 1'b0;
    end
  end

  // R7
  ss_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && !slaveSel) |=> (sBitCnt == '0 && !sPend));

  // R2
  master_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && strb.finishNow) |=> !busyM);

  // R5
  slave_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && strb.sampleNow) |-> !sTxEv);
endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrb_t         strb,
  input  logic              sdiBit,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              rdEn,
  input  logic              wcolClr,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              wcolFlag,
  output logic              done,
  output logic              sdoBit
);
  logic [DATA_W-1:0] shifter, rxBuf;
  logic              sampleBit, inBit;

  assign inBit  = strb.sampleNow ? sdiBit : sampleBit;
  assign sdoBit = shifter[DATA_W-1];
  assign rdData = rxBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter   <= '0;
      rxBuf     <= '0;
      sampleBit <= 1'b0;
      bufFull   <= 1'b0;
      wcolFlag  <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (strb.load)
        shifter <= wrData;
      else if (strb.shiftNow)
        shifter <= {shifter[DATA_W-2:0], inBit};
      if (strb.sampleNow) sampleBit <= sdiBit;
      if (strb.finishNow) rxBuf <= {shifter[DATA_W-2:0], inBit};
      if (strb.finishNow) bufFull <= 1'b1;
      else if (rdEn)      bufFull <= 1'b0;
      if (wrEn && busy)   wcolFlag <= 1'b1;
      else if (wcolClr)   wcolFlag <= 1'b0;
      done <= strb.finishNow;
    end
  end

  // R8
  buf_full_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> done);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strb.finishNow) |=> !bufFull);

  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> wcolFlag);

  // R9
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy && !strb.shiftNow) |=> $stable(shifter));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              clkPol,
  input  logic              txEdge,
  input  logic              sampleEnd,
  input  logic [DIV_W-1:0]  divRatio,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              wcolClr,
  output logic [DATA_W-1:0] rdData,
  output logic              bufFull,
  output logic              wcolFlag,
  output logic              busy,
  output logic              done,
  output logic              sckOut,
  output logic              sdoOut,
  output logic              sdoOe,
  output logic              csnOut,
  input  logic              sckIn,
  input  logic              ssnIn,
  input  logic              sdiIn
);
  xferStrb_t strb;
  logic      sdiBit, slaveSel, sdoBit;

  spi_eng_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .clkPol(clkPol),
    .txEdge(txEdge), .sampleEnd(sampleEnd), .divRatio(divRatio),
    .wrEn(wrEn), .sckIn(sckIn), .ssnIn(ssnIn), .sdiIn(sdiIn),
    .strb(strb), .sdiBit(sdiBit), .busy(busy), .sckOut(sckOut),
    .csnOut(csnOut), .slaveSel(slaveSel)
  );

  spi_eng_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiBit(sdiBit),
    .wrEn(wrEn), .wrData(wrData), .busy(busy), .rdEn(rdEn),
    .wcolClr(wcolClr), .rdData(rdData), .bufFull(bufFull),
    .wcolFlag(wcolFlag), .done(done), .sdoBit(sdoBit)
  );

  assign sdoOut = sdoBit;
  assign sdoOe  = isMaster | slaveSel;
endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic isMaster = 1'b1, clkPol = 1'b0, txEdge = 1'b1, sampleEnd = 1'b0;
  logic [7:0] divRatio = 8'd0, wrData = 8'd0;
  logic wrEn = 1'b0, rdEn = 1'b0, wcolClr = 1'b0;
  logic sckIn = 1'b0, ssnIn = 1'b1, sdiIn = 1'b0;
  logic [7:0] rdData;
  logic bufFull, wcolFlag, busy, done, sckOut, sdoOut, sdoOe, csnOut;

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_engine uut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .clkPol(clkPol),
    .txEdge(txEdge), .sampleEnd(sampleEnd), .divRatio(divRatio),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .wcolClr(wcolClr),
    .rdData(rdData), .bufFull(bufFull), .wcolFlag(wcolFlag), .busy(busy),
    .done(done), .sckOut(sckOut), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .csnOut(csnOut), .sckIn(sckIn), .ssnIn(ssnIn), .sdiIn(sdiIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every done pops one expected received byte (R4 R6 R10)
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R4 R6 received byte", rdData, e);
      end
    end
  end

  task automatic masterXfer(input logic [7:0] txB, first, second,
                            input logic pol, ed, se, input logic [7:0] dv,
                            input int collideAt);
    int cnt, idx, sdoErr, csnErr, expCnt;
    logic prevSck, prevSdo, lead, seen;
    logic [7:0] rxS;
    @(negedge clk);
    isMaster = 1'b1; clkPol = pol; txEdge = ed; sampleEnd = se; divRatio = dv;
    sdiIn = first[7];
    repeat (2) @(negedge clk);
    chk(sckOut == pol && csnOut, "R2 idle level", sckOut, pol);
    expQ.push_back(se ? second : first);
    wrData = txB; wrEn = 1'b1;
    cnt = 0; idx = 0; sdoErr = 0; csnErr = 0; seen = 1'b0; rxS = '0;
    prevSck = pol; prevSdo = sdoOut;
    expCnt = 16 * (int'(dv) + 1) + 1;
    while (!seen && cnt < expCnt + 20) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) wrEn = 1'b0;
      if (collideAt != 0 && cnt == collideAt) begin wrData = ~txB; wrEn = 1'b1; end
      if (collideAt != 0 && cnt == collideAt + 1) wrEn = 1'b0;
      if (busy && csnOut) csnErr++;
      if (sckOut != prevSck) begin
        lead = (prevSck == pol);
        if (ed ? !lead : lead) begin
          if (ed) idx++;
          if (idx < 8) sdiIn = first[7-idx];
        end else begin
          if (sdoOut != prevSdo) sdoErr++;
          rxS = {rxS[6:0], sdoOut};
          if (idx < 8) sdiIn = second[7-idx];
          if (!ed) idx++;
        end
        prevSck = sckOut;
      end
      prevSdo = sdoOut;
      if (done) seen = 1'b1;
    end
    chk(seen && cnt == expCnt, "R2 transfer length", cnt, expCnt);
    chk(rxS == txB, "R1 sdo byte MSB first", rxS, txB);
    chk(sdoErr == 0, "R3 sdo moved on capture edge", sdoErr, 0);
    chk(csnErr == 0, "R1 csn low while busy", csnErr, 0);
    chk(bufFull, "R8 buffer full on completion", bufFull, 1);
    if (collideAt != 0) chk(wcolFlag, "R9 collision flagged", wcolFlag, 1);
    @(negedge clk);
    chk(!done && !busy && sckOut == pol && csnOut, "R10 done single cycle", done, 0);
  endtask

  task automatic slaveXfer(input logic [7:0] txB, rxB, input logic pol, ed, se,
                           input int nBits);
    logic [7:0] capt;
    capt = '0;
    @(negedge clk);
    isMaster = 1'b0; clkPol = pol; txEdge = ed; sampleEnd = se;
    sckIn = pol; ssnIn = 1'b1;
    repeat (4) @(negedge clk);
    wrData = txB; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (nBits == 8) expQ.push_back(rxB);
    ssnIn = 1'b0;
    if (ed) sdiIn = rxB[7];
    repeat (4) @(negedge clk);
    chk(sdoOe, "R7 sdo driven when selected", sdoOe, 1);
    for (int k = 0; k < nBits; k++) begin
      if (ed) begin
        sdiIn = rxB[7-k];
        repeat (HALF) @(negedge clk);
        capt = {capt[6:0], sdoOut};
        sckIn = ~pol;
        repeat (4) @(negedge clk);
        sdiIn = ~rxB[7-k];          // wrong value once the capture edge is past
        repeat (HALF - 4) @(negedge clk);
        sckIn = pol;
      end else begin
        repeat (HALF) @(negedge clk);
        sckIn = ~pol;
        sdiIn = rxB[7-k];
        repeat (HALF) @(negedge clk);
        capt = {capt[6:0], sdoOut};
        sckIn = pol;
        repeat (4) @(negedge clk);
        sdiIn = ~rxB[7-k];
      end
    end
    repeat (6) @(negedge clk);
    if (nBits == 8) begin
      chk(capt == txB, "R6 slave sdo byte", capt, txB);
      chk(bufFull, "R8 slave buffer full", bufFull, 1);
    end
    ssnIn = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdoOe, "R7 sdo released when deselected", sdoOe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clkPol = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !bufFull && !wcolFlag && csnOut && sckOut == 1'b1,
        "R11 reset state", {busy, done, bufFull, wcolFlag, csnOut, sckOut}, 6'b000011);

    // R3 R4: all four edge modes, both capture points
    masterXfer(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b0, 8'd0, 0);
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    chk(!bufFull, "R8 read clears buffer full", bufFull, 0);
    masterXfer(8'h5A, 8'h96, 8'h69, 1'b0, 1'b1, 1'b1, 8'd0, 0);
    masterXfer(8'h81, 8'hF0, 8'h0F, 1'b0, 1'b0, 1'b1, 8'd1, 0);
    masterXfer(8'h7E, 8'h12, 8'hED, 1'b1, 1'b1, 1'b1, 8'd2, 0);
    masterXfer(8'hC6, 8'hB4, 8'h4B, 1'b1, 1'b0, 1'b0, 8'd3, 0);

    // R9: write during a running exchange
    masterXfer(8'h3D, 8'h55, 8'hAA, 1'b0, 1'b1, 1'b0, 8'd1, 7);
    @(negedge clk);
    chk(wcolFlag, "R9 collision flag sticky", wcolFlag, 1);
    wcolClr = 1'b1; @(negedge clk); wcolClr = 1'b0;
    chk(!wcolFlag, "R9 collision flag cleared", wcolFlag, 0);

    // R5 R6: slave with sampleEnd set is still captured mid-bit
    slaveXfer(8'h9C, 8'h5B, 1'b0, 1'b1, 1'b1, 8);
    slaveXfer(8'h2F, 8'hE1, 1'b1, 1'b0, 1'b1, 8);
    slaveXfer(8'hD3, 8'h47, 1'b0, 1'b0, 1'b0, 8);

    // R7: aborted exchange then a full one
    slaveXfer(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 3);
    slaveXfer(8'h6A, 8'hB2, 1'b1, 1'b1, 1'b0, 8);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R10 every byte completed", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule